// File: doc/BRIEF.md
# PLL Feedback Divider Ramp Controller

This controller moves a running PLL's feedback divider (N) to a new value without losing lock, by having the PLL ramp the divider in hardware. A request carries the new N and a one-cycle start strobe. The controller compares the request with the N the PLL runs at now. If they are equal it reports completion at once. Otherwise it walks a fixed write sequence on a masked register-write port: it loads the two ramp step coefficients, puts the PLL into its slowdown mode, writes the new N, and then turns on the dynamic ramp.

Once the ramp is on, the controller samples a synchronized ramp-finished status once per microsecond tick, up to a fixed number of polls. Whatever the outcome, its last write drops both slowdown mode and the ramp enable. After that it reports success or a timeout as a one-cycle pulse. The sequence waits on the tick input between steps and does no other timing. A surrounding clock manager uses it for each frequency change in which only N moves.

Top module: `pll_ndiv_ramp`

## Requirements
- R1: When start_i is accepted and n_req_i equals cur_n_i, done_o pulses on the next cycle. busy_o stays low and wr_valid_o is never asserted for that request.
- R2: A ramp begins with two writes, each of which changes only its own field. The first goes to select 0 (step-A word) with mask 0xFF000000 and data 0x2B000000. The second goes to select 1 (step-B word) with mask 0x00FF0000 and data 0x000B0000.
- R3: The third write goes to select 2 (slowdown word) and sets bit 22 (slowdown mode) only. It comes after both step writes.
- R4: After at least one us_tick_i with slowdown set, the new N is written to select 3 (coefficient word) with mask 0x0000FF00 and the N in bits 15:8. The other bits of that word are kept.
- R5: After at least one further us_tick_i, select 2 is written with bit 31 (ramp enable) set and nothing else changed.
- R6: While the ramp is on, ramp_done_i is sampled only on us_tick_i cycles. The first sampled high value ends the ramp as a success, including on the 500th poll.
- R7: If 500 polls all sample ramp_done_i low, the ramp ends as a timeout and err_o pulses instead of done_o.
- R8: On both outcomes the last write goes to select 2 with mask 0x80400000 and data 0. The report pulse comes on the cycle after that write.
- R9: done_o and err_o are single-cycle pulses and are never high together. busy_o is high from the cycle after an accepted ramp start until the report cycle, where it is low.
- R10: start_i while busy_o is high is ignored. The ramp in progress keeps its target and reports exactly once.
- R11: After reset busy_o, done_o, err_o and wr_valid_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe |
| n_req_i | input | 8 | Requested feedback divider |
| cur_n_i | input | 8 | N field the PLL holds now |
| us_tick_i | input | 1 | One-cycle pulse per microsecond |
| ramp_done_i | input | 1 | Synchronized ramp-finished status |
| wr_valid_o | output | 1 | Register write strobe |
| wr_sel_o | output | 2 | Target word: 0 step-A, 1 step-B, 2 slowdown, 3 coefficient |
| wr_mask_o | output | 32 | Bits the write changes |
| wr_data_o | output | 32 | Write value, applied under the mask |
| busy_o | output | 1 | Ramp sequence in progress |
| done_o | output | 1 | Success pulse |
| err_o | output | 1 | Timeout pulse |

## Verification
The hardest edge is the last poll: a ramp that finishes exactly on poll 500 has to count as a success, and one that finishes a poll later has to count as a timeout. The bench's PLL model raises ramp-done a set number of ticks after it sees the enable bit, and the vector table holds latencies of 499 and 500 to reach both sides of that edge. The model also records, at the time of each write, whether slowdown was set, whether the N field was already new and whether a tick had passed. This lets the bench check the write order and the waits, which the final register values alone would hide.

// File: rtl/pll_ramp_pkg.sv
package pll_ramp_pkg;

    // Bit positions inside the PLL words the PLL itself decodes
    localparam int STEP_W     = 8;
    localparam int STEP_A_LSB = 24;
    localparam int STEP_B_LSB = 16;
    localparam int SLOW_BIT   = 22;
    localparam int RAMP_BIT   = 31;

    typedef enum logic [1:0] {
        SEL_STEP_A = 2'd0,
        SEL_STEP_B = 2'd1,
        SEL_SLOW   = 2'd2,
        SEL_COEF   = 2'd3
    } reg_sel_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_STEP_A,
        OP_STEP_B,
        OP_SLOW_ON,
        OP_WRITE_N,
        OP_RAMP_ON,
        OP_EXIT
    } wr_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_STEP_A,
        ST_STEP_B,
        ST_SLOW_ON,
        ST_WAIT_N,
        ST_WRITE_N,
        ST_WAIT_EN,
        ST_RAMP_ON,
        ST_POLL,
        ST_EXIT
    } ramp_st_e;

endpackage

// File: rtl/pll_ramp_wr_fmt.sv
module pll_ramp_wr_fmt
    import pll_ramp_pkg::*;
#(
    parameter int          N_W        = 8,
    parameter int          N_LSB      = 8,
    parameter int          DATA_W     = 32,
    parameter logic [7:0]  STEP_A_VAL = 8'h2B,
    parameter logic [7:0]  STEP_B_VAL = 8'h0B
) (
    input  wr_op_e              op_i,
    input  logic [N_W-1:0]      n_i,
    output logic                valid_o,
    output reg_sel_e            sel_o,
    output logic [DATA_W-1:0]   mask_o,
    output logic [DATA_W-1:0]   data_o
);

    localparam logic [DATA_W-1:0] STEP_ONES = {{(DATA_W-STEP_W){1'b0}}, {STEP_W{1'b1}}};
    localparam logic [DATA_W-1:0] N_ONES    = {{(DATA_W-N_W){1'b0}}, {N_W{1'b1}}};
    localparam logic [DATA_W-1:0] ONE       = {{(DATA_W-1){1'b0}}, 1'b1};
    localparam logic [DATA_W-1:0] SLOW_M    = ONE << SLOW_BIT;
    localparam logic [DATA_W-1:0] RAMP_M    = ONE << RAMP_BIT;

    always_comb begin
        valid_o = 1'b1;
        sel_o   = SEL_SLOW;
        mask_o  = '0;
        data_o  = '0;
        case (op_i)
            OP_STEP_A: begin
                sel_o  = SEL_STEP_A;
                mask_o = STEP_ONES << STEP_A_LSB;
                data_o = {{(DATA_W-8){1'b0}}, STEP_A_VAL} << STEP_A_LSB;
            end
            OP_STEP_B: begin
                sel_o  = SEL_STEP_B;
                mask_o = STEP_ONES << STEP_B_LSB;
                data_o = {{(DATA_W-8){1'b0}}, STEP_B_VAL} << STEP_B_LSB;
            end
            OP_SLOW_ON: begin
                mask_o = SLOW_M;
                data_o = SLOW_M;
            end
            OP_WRITE_N: begin
                sel_o  = SEL_COEF;
                mask_o = N_ONES << N_LSB;
                data_o = {{(DATA_W-N_W){1'b0}}, n_i} << N_LSB;
            end
            OP_RAMP_ON: begin
                mask_o = RAMP_M;
                data_o = RAMP_M;
            end
            OP_EXIT: begin
                mask_o = SLOW_M | RAMP_M;
                data_o = '0;
            end
            default: valid_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/pll_ramp_poll_cnt.sv
module pll_ramp_poll_cnt #(
    parameter int POLL_MAX = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);

    localparam int CW = $clog2(POLL_MAX + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)
            cnt_d = '0;
        else if (inc_i)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == CW'(POLL_MAX - 1));

    // R7: the poll count never runs past the last allowed poll
    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(POLL_MAX));

    // R7: counting on the last poll would overrun the window
    a_r7_no_inc_at_last: assert property (@(posedge clk) disable iff (!rst_n)
        last_o && !clr_i |-> !inc_i);

endmodule

// File: rtl/pll_ndiv_ramp.sv
module pll_ndiv_ramp
    import pll_ramp_pkg::*;
#(
    parameter int          N_W        = 8,
    parameter int          N_LSB      = 8,
    parameter int          DATA_W     = 32,
    parameter int          POLL_MAX   = 500,
    parameter logic [7:0]  STEP_A_VAL = 8'h2B,
    parameter logic [7:0]  STEP_B_VAL = 8'h0B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [N_W-1:0]    n_req_i,
    input  logic [N_W-1:0]    cur_n_i,
    input  logic              us_tick_i,
    input  logic              ramp_done_i,
    output logic              wr_valid_o,
    output logic [1:0]        wr_sel_o,
    output logic [DATA_W-1:0] wr_mask_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o
);

    typedef struct packed {
        ramp_st_e       st;
        logic [N_W-1:0] tgt;
        logic           fail;
        logic           done;
        logic           err;
    } ctl_t;

    ctl_t     c_d, c_q;
    wr_op_e   op;
    logic     cnt_clr, cnt_inc, cnt_last;
    reg_sel_e sel;

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        c_d.err  = 1'b0;
        op       = OP_NONE;
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;
        case (c_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (n_req_i == cur_n_i) begin
                        c_d.done = 1'b1;
                    end else begin
                        c_d.tgt  = n_req_i;
                        c_d.fail = 1'b0;
                        c_d.st   = ST_STEP_A;
                    end
                end
            end
            ST_STEP_A: begin
                op     = OP_STEP_A;
                c_d.st = ST_STEP_B;
            end
            ST_STEP_B: begin
                op     = OP_STEP_B;
                c_d.st = ST_SLOW_ON;
            end
            ST_SLOW_ON: begin
                op     = OP_SLOW_ON;
                c_d.st = ST_WAIT_N;
            end
            ST_WAIT_N: begin
                if (us_tick_i) c_d.st = ST_WRITE_N;
            end
            ST_WRITE_N: begin
                op     = OP_WRITE_N;
                c_d.st = ST_WAIT_EN;
            end
            ST_WAIT_EN: begin
                if (us_tick_i) c_d.st = ST_RAMP_ON;
            end
            ST_RAMP_ON: begin
                op      = OP_RAMP_ON;
                cnt_clr = 1'b1;
                c_d.st  = ST_POLL;
            end
            ST_POLL: begin
                if (us_tick_i) begin
                    if (ramp_done_i) begin
                        c_d.fail = 1'b0;
                        c_d.st   = ST_EXIT;
                    end else if (cnt_last) begin
                        c_d.fail = 1'b1;
                        c_d.st   = ST_EXIT;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
            end
            ST_EXIT: begin
                op       = OP_EXIT;
                c_d.done = !c_q.fail;
                c_d.err  = c_q.fail;
                c_d.st   = ST_IDLE;
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.st   <= ST_IDLE;
            c_q.tgt  <= '0;
            c_q.fail <= 1'b0;
            c_q.done <= 1'b0;
            c_q.err  <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    pll_ramp_poll_cnt #(
        .POLL_MAX (POLL_MAX)
    ) u_poll (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (cnt_clr),
        .inc_i  (cnt_inc),
        .last_o (cnt_last)
    );

    pll_ramp_wr_fmt #(
        .N_W        (N_W),
        .N_LSB      (N_LSB),
        .DATA_W     (DATA_W),
        .STEP_A_VAL (STEP_A_VAL),
        .STEP_B_VAL (STEP_B_VAL)
    ) u_fmt (
        .op_i    (op),
        .n_i     (c_q.tgt),
        .valid_o (wr_valid_o),
        .sel_o   (sel),
        .mask_o  (wr_mask_o),
        .data_o  (wr_data_o)
    );

    assign wr_sel_o = sel;
    assign busy_o   = (c_q.st != ST_IDLE);
    assign done_o   = c_q.done;
    assign err_o    = c_q.err;

    // R1: a request for the current N reports at once without entering the sequence
    a_r1_skip_now: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_IDLE && start_i && n_req_i == cur_n_i) |=> (done_o && !busy_o));

    // R1: no register write outside a running sequence
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !wr_valid_o);

    // R6: the poll state is left only on a tick
    a_r6_tick_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_POLL && !us_tick_i) |=> (c_q.st == ST_POLL));

    // R8: a report after a sequence follows the write that drops both mode bits
    a_r8_exit_first: assert property (@(posedge clk) disable iff (!rst_n)
        ((done_o || err_o) && $past(busy_o)) |->
        $past(wr_valid_o && sel == SEL_SLOW && wr_mask_o[SLOW_BIT] &&
              wr_mask_o[RAMP_BIT] && !wr_data_o[SLOW_BIT] && !wr_data_o[RAMP_BIT]));

    // R9: reports are single-cycle and mutually exclusive
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r9_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));

    // R10: the target stays fixed for the whole sequence
    a_r10_tgt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> (c_q.tgt == $past(c_q.tgt)));

endmodule

// File: tb/tb_pll_ndiv_ramp.sv
module tb_pll_ndiv_ramp;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  n_req = '0;
    logic [7:0]  cur_n;
    logic        us_tick;
    logic        ramp_done;
    logic        wr_valid;
    logic [1:0]  wr_sel;
    logic [31:0] wr_mask, wr_data;
    logic        busy, done, err;

    always #4 clk = ~clk;

    pll_ndiv_ramp dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .n_req_i     (n_req),
        .cur_n_i     (cur_n),
        .us_tick_i   (us_tick),
        .ramp_done_i (ramp_done),
        .wr_valid_o  (wr_valid),
        .wr_sel_o    (wr_sel),
        .wr_mask_o   (wr_mask),
        .wr_data_o   (wr_data),
        .busy_o      (busy),
        .done_o      (done),
        .err_o       (err)
    );

    localparam logic [31:0] INIT_A    = 32'h11C3_00A5;
    localparam logic [31:0] INIT_B    = 32'hA5FF_1234;
    localparam logic [31:0] INIT_SLOW = 32'h0000_1234;

    // PLL register model
    logic [1:0]  tcnt;
    logic [31:0] m_a, m_b, m_slow, m_coef;
    int          wcount, t_slow, t_n, en_ticks;
    bit          n_written, ok_slow, ok_n, ok_en;
    bit          mdl_load = 1'b0;
    logic [31:0] ld_coef = '0;
    int          lat = 0;
    logic [7:0]  exp_n = '0;

    assign us_tick   = (tcnt == 2'd3);
    assign cur_n     = m_coef[15:8];
    assign ramp_done = m_slow[31] && (en_ticks >= lat);

    always @(posedge clk) begin
        if (!rst_n) tcnt <= '0;
        else        tcnt <= tcnt + 2'd1;
    end

    always @(posedge clk) begin
        if (mdl_load || !rst_n) begin
            m_a <= INIT_A; m_b <= INIT_B; m_slow <= INIT_SLOW; m_coef <= ld_coef;
            wcount <= 0; t_slow <= 0; t_n <= 0; en_ticks <= 0;
            n_written <= 0; ok_slow <= 0; ok_n <= 0; ok_en <= 0;
        end else begin
            if (us_tick) begin
                if (m_slow[22]) t_slow <= t_slow + 1;
                if (n_written)  t_n    <= t_n + 1;
                if (m_slow[31]) en_ticks <= en_ticks + 1;
            end
            if (wr_valid) begin
                wcount <= wcount + 1;
                case (wr_sel)
                    2'd0: m_a <= (m_a & ~wr_mask) | (wr_data & wr_mask);
                    2'd1: m_b <= (m_b & ~wr_mask) | (wr_data & wr_mask);
                    2'd2: begin
                        m_slow <= (m_slow & ~wr_mask) | (wr_data & wr_mask);
                        if (wr_mask == 32'h0040_0000 && wr_data[22])
                            ok_slow <= (m_a[31:24] == 8'h2B) && (m_b[23:16] == 8'h0B) && wcount == 2;
                        if (wr_mask == 32'h8000_0000 && wr_data[31])
                            ok_en <= n_written && (t_n >= 1) && (m_coef[15:8] == exp_n);
                    end
                    default: begin
                        m_coef    <= (m_coef & ~wr_mask) | (wr_data & wr_mask);
                        ok_n      <= m_slow[22] && !m_slow[31] && (t_slow >= 1);
                        n_written <= 1'b1;
                    end
                endcase
            end
        end
    end

    int total = 0;
    int bad = 0;

    task automatic chk(input bit ok, input string what, input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, expv);
        end
    endtask

    // kind: 0 ramp succeeds, 1 ramp times out, 2 N unchanged
    typedef struct packed {
        logic [7:0]  n;
        logic [31:0] coef;
        logic [15:0] lat;
        logic [1:0]  kind;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{8'h40, 32'h0012_3005, 16'd3,     2'd0},
        '{8'h30, 32'h0012_3005, 16'd3,     2'd2},
        '{8'h20, 32'h0001_FF01, 16'd0,     2'd0},
        '{8'hFF, 32'h003F_0001, 16'd499,   2'd0},
        '{8'h10, 32'h000A_8003, 16'd500,   2'd1},
        '{8'h55, 32'h0000_5502, 16'd0,     2'd2},
        '{8'h01, 32'h0002_8004, 16'hFFFF,  2'd1}
    };

    task automatic run_one(input vec_t v, input bit poke);
        bit saw_busy = 0;
        bit got_done = 0;
        bit got_err  = 0;
        bit seen     = 0;
        int extra    = 0;
        logic [31:0] exp_coef;
        @(negedge clk);
        mdl_load = 1'b1; ld_coef = v.coef; lat = int'(v.lat); exp_n = v.n;
        @(negedge clk);
        mdl_load = 1'b0;
        start = 1'b1; n_req = v.n;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            if (busy) saw_busy = 1;
            if (done || err) begin
                got_done = done; got_err = err; seen = 1;
                break;
            end
            if (poke && i == 12) begin start = 1'b1; n_req = 8'h77; end
            else start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        chk(seen, "R9 report seen", seen, 1);
        chk(got_done == (v.kind != 2'd1), "R6/R7 done outcome", got_done, v.kind != 2'd1);
        chk(got_err == (v.kind == 2'd1), "R7 err outcome", got_err, v.kind == 2'd1);
        chk(!busy, "R9 busy low at report", busy, 0);
        chk(m_slow == INIT_SLOW, "R8 slowdown word restored", m_slow, INIT_SLOW);
        exp_coef = (v.kind == 2'd2) ? v.coef : ((v.coef & 32'hFFFF_00FF) | {16'h0, v.n, 8'h00});
        chk(m_coef == exp_coef, "R4 coefficient word", m_coef, exp_coef);
        if (v.kind == 2'd2) begin
            chk(wcount == 0, "R1 no writes on equal N", wcount, 0);
            chk(!saw_busy, "R1 busy stays low", saw_busy, 0);
            chk(m_a == INIT_A && m_b == INIT_B, "R1 step words untouched", m_a, INIT_A);
        end else begin
            chk(wcount == 6, "R8 write count", wcount, 6);
            chk(saw_busy, "R9 busy during ramp", saw_busy, 1);
            chk(m_a == 32'h2BC3_00A5, "R2 step-A word", m_a, 32'h2BC3_00A5);
            chk(m_b == 32'hA50B_1234, "R2 step-B word", m_b, 32'hA50B_1234);
            chk(ok_slow, "R3 slowdown after steps", ok_slow, 1);
            chk(ok_n, "R4 N after slowdown and tick", ok_n, 1);
            chk(ok_en, "R5 enable after N and tick", ok_en, 1);
            chk(en_ticks == ((v.kind == 2'd1) ? 500 : int'(v.lat) + 1), "R6/R7 poll count",
                en_ticks, (v.kind == 2'd1) ? 500 : int'(v.lat) + 1);
        end
        @(negedge clk);
        chk(!done && !err, "R9 single-cycle report", {done, err}, 0);
        for (int i = 0; i < 20; i++) begin
            if (done || err || busy) extra++;
            @(negedge clk);
        end
        chk(extra == 0, "R10 no further activity", extra, 0);
    endtask

    task automatic main_seq();
        repeat (3) @(negedge clk);
        chk(!busy && !done && !err && !wr_valid, "R11 reset outputs",
            {busy, done, err, wr_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !err && !wr_valid, "R11 idle after reset",
            {busy, done, err, wr_valid}, 0);
        for (int k = 0; k < NV; k++) run_one(VECS[k], 1'b0);
        // R10: start with another N in the middle of a ramp
        run_one('{8'h66, 32'h0000_2001, 16'd5, 2'd0}, 1'b1);
    endtask

    initial begin
        bit wd = 0;
        fork
            main_seq();
            begin
                repeat (150000) @(posedge clk);
                wd = 1;
            end
        join_any
        disable fork;
        if (wd) begin
            total++; bad++;
            $display("FAIL watchdog actual=1 expected=0");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule